// File: doc/BRIEF.md
# Sensor Horizontal Line Readout Timer

This block produces the horizontal timing for one sensor line, counted in pixel clocks. A one-cycle request from the vertical sequencer starts a line. The block first raises a one-cycle phase warning. The vertical sequencer uses this warning to move its line-phase signal. The block then holds the pixel-read strobe high for two cycles. After that it reads the line in two passes. The first pass covers the even columns, with the column select high. The second pass covers the odd columns, with the column select low. Each pass begins with a four-cycle line-start pulse and is followed by a run of column shift cycles.

During a pass, the first and the last shifted column are not valid. Only the columns between them are flagged as valid pixels, and each valid pixel gets a column index starting at zero. A mode input halves the number of shifted columns, for horizontal subsampling. A column limit can end each pass after a chosen number of valid pixels, for partial-line reads. An active-low clear drops the scan back to idle on the next clock. When a line ends, either normally or through a clear, the block issues a one-cycle done pulse.

Top module: `hline_timer`

## Requirements
- R1: Each pass begins with a line-start pulse `ls` exactly 4 cycles long, so a full line has exactly two such pulses.
- R2: `ec` is 1 from the phase warning through the end of the even pass and 0 during the odd pass. It is also 0 while idle.
- R3: At full resolution (`sub_mode`=0) each pass has 514 consecutive `pix_shift` cycles. The first of these is the cycle right after the last `ls` cycle. `pix_valid` is high on all of them except the first and the last, which gives 512 valid pixels.
- R4: With `sub_mode`=1 each pass has 258 `pix_shift` cycles, of which the middle 256 are valid.
- R5: `even_warn` is high for one cycle per line, exactly 2 cycles before the first `ls` of the line rises.
- R6: `pxrd` is high for exactly the 2 cycles just before the first `ls` of a line, and at no other time.
- R7: A low `clr_n` sampled at a clock edge makes `ls`, `pxrd` and `pix_shift` low after that edge and returns the block to idle. `line_done` pulses then only if a line was in progress. Clear takes priority over `line_req`.
- R8: Across the valid pixels of a pass, `col_idx` counts 0, 1, 2 and so on in steps of one. It is 0 whenever `pix_valid` is low.
- R9: `line_done` is high for one cycle, in the cycle after the last shift cycle of the odd pass.
- R10: A `col_limit` L with 0 < L < V, where V is 512 or 256 depending on the mode, ends each pass after the pixel with index L-1. That gives L+1 shift cycles and L valid pixels per pass. An L of 0, or of V or more, gives the full pass.
- R11: `sub_mode` and `col_limit` are captured when a request is accepted. A `line_req` that arrives while a line is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low scan clear |
| line_req | input | 1 | Start-of-line request, accepted when idle |
| sub_mode | input | 1 | 1 = horizontal subsampling (half the columns) |
| col_limit | input | 10 | Valid pixels per pass, 0 = full |
| ls | output | 1 | Line-start pulse, 4 cycles per pass |
| ec | output | 1 | Column select: 1 = even pass, 0 = odd pass |
| pxrd | output | 1 | Pixel-read strobe before the first line start |
| even_warn | output | 1 | Warning for the line-phase change |
| pix_shift | output | 1 | A column is shifted out this cycle |
| pix_valid | output | 1 | The shifted column is a valid pixel |
| col_idx | output | 9 | Index of the valid pixel |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
Some properties are checked on every cycle. These are the line-start pulse length, the warning and read-strobe lead before the even-pass line start, and the rule that valid pixels occur only in shift cycles. They also cover the index stepping by one, `ec` holding steady through a pulse, the clear forcing the outputs low, and `line_done` lasting a single cycle. Other behaviours can only be shown by the bench scenarios. These are the exact shift and valid counts in both modes, the column-limit cases on both sides of the pass width, requests ignored while busy, and the pixels emitted before a mid-scan clear.

// File: rtl/hlt_pkg.sv
package hlt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_LS   = 2'd2,
    PH_SCAN = 2'd3
  } phase_t;
endpackage

// File: rtl/hlt_seq.sv
module hlt_seq
  import hlt_pkg::*;
#(
  parameter int VALID_COLS = 512,
  parameter int LS_LEN     = 4,
  parameter int PRE_LEN    = 2,
  localparam int LIM_W     = $clog2(VALID_COLS) + 1,
  localparam int CNT_W     = LIM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             line_req,
  input  logic             sub_mode,
  input  logic [LIM_W-1:0] col_limit,
  output phase_t           phase_o,
  output logic             odd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] vcnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(VALID_COLS);
  localparam logic [CNT_W-1:0] HALF_N = CNT_W'(VALID_COLS / 2);

  phase_t           phase_q, phase_d;
  logic             odd_q, odd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] vcnt_q, vcnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             done_q, done_d;

  logic [CNT_W-1:0] full_w, lim_w, eff_w;

  always_comb begin
    full_w = sub_mode ? HALF_N : FULL_N;
    lim_w  = {1'b0, col_limit};
    eff_w  = ((lim_w == '0) || (lim_w >= full_w)) ? full_w : lim_w;
  end

  always_comb begin
    phase_d = phase_q;
    odd_d   = odd_q;
    cnt_d   = cnt_q;
    vcnt_d  = vcnt_q;
    last_d  = last_q;
    done_d  = 1'b0;
    if (!clr_n) begin
      phase_d = PH_IDLE;
      odd_d   = 1'b0;
      cnt_d   = '0;
      done_d  = (phase_q != PH_IDLE);
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (line_req) begin
            phase_d = PH_PRE;
            odd_d   = 1'b0;
            cnt_d   = '0;
            vcnt_d  = eff_w;
            last_d  = (eff_w == full_w) ? (full_w + CNT_W'(1)) : eff_w;
          end
        end
        PH_PRE: begin
          if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
            phase_d = PH_LS;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_LS: begin
          if (cnt_q == CNT_W'(LS_LEN - 1)) begin
            phase_d = PH_SCAN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_SCAN: begin
          if (cnt_q == last_q) begin
            cnt_d = '0;
            if (!odd_q) begin
              phase_d = PH_LS;
              odd_d   = 1'b1;
            end else begin
              phase_d = PH_IDLE;
              odd_d   = 1'b0;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      odd_q   <= 1'b0;
      cnt_q   <= '0;
      vcnt_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      odd_q   <= odd_d;
      cnt_q   <= cnt_d;
      vcnt_q  <= vcnt_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign odd_o   = odd_q;
  assign cnt_o   = cnt_q;
  assign vcnt_o  = vcnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/hlt_decode.sv
module hlt_decode
  import hlt_pkg::*;
#(
  parameter int VALID_COLS = 512,
  localparam int IDX_W     = $clog2(VALID_COLS),
  localparam int CNT_W     = IDX_W + 2
) (
  input  phase_t           phase_i,
  input  logic             odd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] vcnt_i,
  output logic             ls_o,
  output logic             ec_o,
  output logic             pxrd_o,
  output logic             warn_o,
  output logic             shift_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    ls_o    = (phase_i == PH_LS);
    pxrd_o  = (phase_i == PH_PRE);
    warn_o  = (phase_i == PH_PRE) && (cnt_i == '0);
    ec_o    = (phase_i != PH_IDLE) && !odd_i;
    shift_o = (phase_i == PH_SCAN);
    valid_o = shift_o && (cnt_i != '0) && (cnt_i <= vcnt_i);
    idx_o   = valid_o ? IDX_W'(cnt_i - CNT_W'(1)) : '0;
  end
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hlt_pkg::*;
#(
  parameter int VALID_COLS = 512,
  parameter int LS_LEN     = 4,
  parameter int PRE_LEN    = 2,
  localparam int IDX_W     = $clog2(VALID_COLS),
  localparam int LIM_W     = IDX_W + 1,
  localparam int CNT_W     = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             line_req,
  input  logic             sub_mode,
  input  logic [LIM_W-1:0] col_limit,
  output logic             ls,
  output logic             ec,
  output logic             pxrd,
  output logic             even_warn,
  output logic             pix_shift,
  output logic             pix_valid,
  output logic [IDX_W-1:0] col_idx,
  output logic             line_done
);
  phase_t           phase_w;
  logic             odd_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] vcnt_w;

  hlt_seq #(
    .VALID_COLS(VALID_COLS),
    .LS_LEN    (LS_LEN),
    .PRE_LEN   (PRE_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .line_req (line_req),
    .sub_mode (sub_mode),
    .col_limit(col_limit),
    .phase_o  (phase_w),
    .odd_o    (odd_w),
    .cnt_o    (cnt_w),
    .vcnt_o   (vcnt_w),
    .done_o   (line_done)
  );

  hlt_decode #(
    .VALID_COLS(VALID_COLS)
  ) u_dec (
    .phase_i(phase_w),
    .odd_i  (odd_w),
    .cnt_i  (cnt_w),
    .vcnt_i (vcnt_w),
    .ls_o   (ls),
    .ec_o   (ec),
    .pxrd_o (pxrd),
    .warn_o (even_warn),
    .shift_o(pix_shift),
    .valid_o(pix_valid),
    .idx_o  (col_idx)
  );
endmodule

// File: rtl/hlt_checker.sv
module hlt_checker #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             ls,
  input logic             ec,
  input logic             pxrd,
  input logic             even_warn,
  input logic             pix_shift,
  input logic             pix_valid,
  input logic [IDX_W-1:0] col_idx,
  input logic             line_done
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (ls && run_q != 4'hF) run_q <= run_q + 4'd1;
    else if (!ls) run_q <= '0;
  end

  p_ls_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 4'd4);

  p_ls_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls) && $past(clr_n) |-> run_q == 4'd4);

  p_ec_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ls && $past(ls) |-> $stable(ec));

  p_valid_in_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_shift);

  p_warn_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) && ec |-> $past(even_warn, 2));

  p_pxrd_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) && ec |-> $past(pxrd));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ls, pxrd, pix_shift}));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !ls && !pxrd && !pix_shift);

  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && $past(pix_valid) |-> col_idx == $past(col_idx) + IDX_W'(1));

  p_idx_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> col_idx == '0);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
endmodule

bind hline_timer hlt_checker #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .ls       (ls),
  .ec       (ec),
  .pxrd     (pxrd),
  .even_warn(even_warn),
  .pix_shift(pix_shift),
  .pix_valid(pix_valid),
  .col_idx  (col_idx),
  .line_done(line_done)
);

// File: tb/hline_timer_bench.sv
module hline_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       line_req = 1'b0;
  logic       sub_mode = 1'b0;
  logic [9:0] col_limit = '0;
  logic       ls, ec, pxrd, even_warn, pix_shift, pix_valid, line_done;
  logic [8:0] col_idx;

  hline_timer u_hline_timer (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .line_req(line_req),
    .sub_mode(sub_mode), .col_limit(col_limit), .ls(ls), .ec(ec),
    .pxrd(pxrd), .even_warn(even_warn), .pix_shift(pix_shift),
    .pix_valid(pix_valid), .col_idx(col_idx), .line_done(line_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_q[$];

  int cyc = 0, warn_cyc = -100, lead = -1, pxrd_pre = 0, pxrd_cnt = 0;
  int ls_run = 0, ls_pulses = 0, ls_badlen = 0, warn_cnt = 0;
  int sh_even = 0, sh_odd = 0, done_cnt = 0, idx_bad = 0;
  logic ls_prev = 0, pxrd_prev = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every valid pixel
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (even_warn) begin warn_cyc = cyc; warn_cnt++; end
      if (pxrd) pxrd_cnt++;
      if (ls && !ls_prev && ec) begin
        lead = cyc - warn_cyc;
        pxrd_pre = pxrd_prev;
      end
      if (ls) ls_run++;
      else if (ls_prev) begin
        ls_pulses++;
        if (ls_run != 4) ls_badlen++;
        ls_run = 0;
      end
      if (pix_shift) begin
        if (ec) sh_even++; else sh_odd++;
      end
      if (pix_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected valid pixel", int'(col_idx), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(e == (int'(ec) * 1024 + int'(col_idx)), "R8 ec*1024+col_idx",
                int'(ec) * 1024 + int'(col_idx), e);
        end
      end else if (col_idx != 0) idx_bad++;
      if (line_done) done_cnt++;
      ls_prev = ls;
      pxrd_prev = pxrd;
    end
  end

  task automatic clr_stats();
    lead = -1; pxrd_pre = 0; pxrd_cnt = 0; ls_run = 0; ls_pulses = 0;
    ls_badlen = 0; warn_cnt = 0; sh_even = 0; sh_odd = 0; done_cnt = 0; idx_bad = 0;
  endtask

  task automatic push_pass(input int ecv, input int nvalid);
    for (int i = 0; i < nvalid; i++) exp_q.push_back(ecv * 1024 + i);
  endtask

  task automatic start_line(input bit sm, input int lim);
    @(negedge clk);
    sub_mode = sm;
    col_limit = 10'(lim);
    line_req = 1'b1;
    @(negedge clk);
    line_req = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) begin
      @(negedge clk);
      #1;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic run_full(input bit sm, input int lim, input int nvalid, input string tag);
    clr_stats();
    push_pass(1, nvalid);
    push_pass(0, nvalid);
    start_line(sm, lim);
    wait_done();
    check(sh_even == nvalid + 2 || (nvalid < (sm ? 256 : 512) && sh_even == nvalid + 1),
          {tag, " even shift count"}, sh_even, nvalid + 2);
    check(sh_odd == sh_even, {tag, " odd shift count"}, sh_odd, sh_even);
    check(exp_q.size() == 0, {tag, " valid pixels missing"}, exp_q.size(), 0);
    check(ls_pulses == 2 && ls_badlen == 0, "R1 line-start pulses of 4", ls_pulses, 2);
    check(lead == 2 && warn_cnt == 1, "R5 warning lead", lead, 2);
    check(pxrd_cnt == 2 && pxrd_pre == 1, "R6 read strobe cycles", pxrd_cnt, 2);
    check(done_cnt == 1, "R9 done pulses", done_cnt, 1);
    check(idx_bad == 0, "R8 index nonzero while invalid", idx_bad, 0);
    check(ec == 1'b0, "R2 ec idle", int'(ec), 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check({ls, ec, pxrd, even_warn, pix_shift, pix_valid, line_done} == 7'b0 && col_idx == 0,
          "R7 reset outputs low", int'({ls, ec, pxrd, even_warn, pix_shift, pix_valid}), 0);

    // R3: full resolution 514 shifts / 512 valid
    run_full(1'b0, 0, 512, "R3");
    check(sh_even == 514, "R3 full pass shifts", sh_even, 514);
    // R4: subsampled 258 / 256
    run_full(1'b1, 0, 256, "R4");
    check(sh_even == 258, "R4 sub pass shifts", sh_even, 258);
    // R10: limit below width ends pass after L valid pixels
    run_full(1'b0, 10, 10, "R10 lim10");
    check(sh_even == 11, "R10 limited shifts", sh_even, 11);
    // R10: limit at or above width gives full pass
    run_full(1'b1, 300, 256, "R10 lim300 sub");
    check(sh_odd == 258, "R10 over-limit sub shifts", sh_odd, 258);
    run_full(1'b0, 512, 512, "R10 lim512");
    check(sh_odd == 514, "R10 equal-limit shifts", sh_odd, 514);

    // R11: request while busy is ignored, mode latched at start
    clr_stats();
    push_pass(1, 512);
    push_pass(0, 512);
    start_line(1'b0, 0);
    repeat (50) @(negedge clk);
    sub_mode = 1'b1; col_limit = 10'd5; line_req = 1'b1;
    @(negedge clk);
    line_req = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    #1;
    check(sh_even == 514 && sh_odd == 514, "R11 busy request ignored", sh_odd, 514);
    check(done_cnt == 1 && exp_q.size() == 0, "R11 single line", done_cnt, 1);
    exp_q.delete();

    // R7: clear mid even pass
    clr_stats();
    push_pass(1, 100);
    @(negedge clk);
    sub_mode = 1'b0; col_limit = '0; line_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_req = 1'b0;
    repeat (106) @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    #1;
    check(line_done == 1'b1, "R7 done after clear", int'(line_done), 1);
    check(!ls && !pix_shift && !pxrd && !ec, "R7 outputs low after clear",
          int'({ls, pix_shift, pxrd, ec}), 0);
    repeat (20) @(negedge clk);
    #1;
    check(sh_even == 101 && sh_odd == 0, "R7 shifts before clear", sh_even, 101);
    check(exp_q.size() == 0 && ls_pulses == 1, "R7 pixels before clear", exp_q.size(), 0);
    check(done_cnt == 1, "R7 one done on clear", done_cnt, 1);
    exp_q.delete();

    // R7: clear while idle, with a request at the same time
    clr_stats();
    @(negedge clk);
    clr_n = 1'b0; line_req = 1'b1;
    @(negedge clk);
    clr_n = 1'b1; line_req = 1'b0;
    #1;
    check(line_done == 1'b0, "R7 no done on idle clear", int'(line_done), 0);
    repeat (10) @(negedge clk);
    #1;
    check(pxrd_cnt == 0 && ls_pulses == 0 && sh_even == 0, "R7 clear beats request",
          pxrd_cnt + ls_pulses, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule